// File: doc/BRIEF.md
# Indexed Configuration Window with SMBus Port Router

This block gives software a two-address window onto a small configuration space. A byte written at window address 0 becomes the current index. Window address 1 then reads or writes the register that the index names. Four consecutive registers are implemented, starting at index 0x2C:

| Index | Contents |
|-------|----------|
| 0x2C | Controller enable (bit 0), low byte of the controller base, primary port-select field (bits 2:1) |
| 0x2D | High byte of the controller base |
| 0x2E | Alternate port-select field (bits 2:1) |
| 0x2F | Source choice (bit 0) |

The decoded controller enable and base address are driven out continuously.

The port-select field picks which one of four downstream SMBus segments is connected to a single host controller. The field can live in either of two registers, and a bit in a third register chooses between them at run time. The routing is open-drain. The host's pull-low enables go only to the selected segment, and only that segment's line levels return to the host. A new selection is applied only while the host controller reports idle. Until then the new selection is held pending, so a transfer in progress is never cut across segments.

Top module: `cfgwin_port_router`

## Requirements
- R1: After a synchronous reset, the index is 0, all four registers read 0x00, `port_sel` is 0, `ctrl_en` is 0, `ctrl_base` is 0x0000 and `sel_pending` is 0.
- R2: A write with `win_sel`=0 loads the index. A read with `win_sel`=0 returns the index. Read data appears on `win_rdata` in the cycle after the read strobe and holds until the next read.
- R3: A write with `win_sel`=1 changes only the register the index names. The other registers keep their values. When the index is outside 0x2C..0x2F, the write is ignored and a read returns 0x00.
- R4: All eight bits of each implemented register read back exactly as written, including bits outside the defined fields.
- R5: `ctrl_en` equals bit 0 of register 0x2C.
- R6: `ctrl_base` equals {reg 0x2D, reg 0x2C} AND 0xFFE0.
- R7: The requested port is bits 2:1 of register 0x2C when bit 0 of register 0x2F is 0, and bits 2:1 of register 0x2E when that bit is 1.
- R8: While `ctrl_busy` is low, `port_sel` takes the requested port at the first clock edge after the write that changed it. When no write occurs and `ctrl_busy` is low, `sel_pending` is 0 in the next cycle.
- R9: While `ctrl_busy` is high, `port_sel` does not change and `sel_pending` is 1 whenever the request differs from `port_sel`. The request is applied at the first edge at which `ctrl_busy` is low.
- R10: Only the port whose code equals `port_sel` gets the host's SCL/SDA pull-low enables. All other ports have their enables at 0 (released). `host_scl_in`/`host_sda_in` follow the selected port's inputs only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_wr | input | 1 | Window write strobe |
| win_rd | input | 1 | Window read strobe |
| win_sel | input | 1 | Window address: 0 index, 1 data |
| win_wdata | input | 8 | Write data |
| win_rdata | output | 8 | Registered read data |
| ctrl_busy | input | 1 | Host controller busy |
| ctrl_en | output | 1 | Controller enable |
| ctrl_base | output | 16 | Masked controller base address |
| port_sel | output | 2 | Active routed port |
| sel_pending | output | 1 | Requested port differs from active port |
| host_scl_oe | input | 1 | Host SCL pull-low enable |
| host_sda_oe | input | 1 | Host SDA pull-low enable |
| host_scl_in | output | 1 | SCL level returned to host |
| host_sda_in | output | 1 | SDA level returned to host |
| port_scl_oe | output | 4 | Per-port SCL pull-low enables |
| port_sda_oe | output | 4 | Per-port SDA pull-low enables |
| port_scl_in | input | 4 | Per-port SCL levels |
| port_sda_in | input | 4 | Per-port SDA levels |

## Verification
A corrupted index or register byte shows up on the data-window read one cycle after the read strobe. If the corrupted byte holds the enable or base, it also shows on `ctrl_en` or `ctrl_base` in the same cycle. A wrong source choice or a mis-gated hold appears on `port_sel` one edge after the write or after busy drops, and on the per-port enables in that same cycle. The bench therefore samples every output the cycle after each change. It also drives writes while the controller is busy, to catch a selection that leaks through early.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  typedef enum logic {
    WIN_INDEX = 1'b0,
    WIN_DATA  = 1'b1
  } win_port_e;

  localparam int CFG_REG_COUNT  = 4;
  localparam int REG_LOW_OFF    = 0;
  localparam int REG_HIGH_OFF   = 1;
  localparam int REG_ALT_OFF    = 2;
  localparam int REG_CHOOSE_OFF = 3;
  localparam int SEL_FIELD_LSB  = 1;
  localparam int EN_BIT         = 0;
  localparam int CHOOSE_BIT     = 0;
endpackage

// File: rtl/cfgwin_space.sv
module cfgwin_space
  import cfgwin_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_BASE  = 8'h2C,
  parameter int SEL_W     = 2,
  parameter logic [2*DATA_W-1:0] BASE_MASK = 16'hFFE0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                rd,
  input  logic                sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                en_bit,
  output logic [2*DATA_W-1:0] base,
  output logic                src_alt,
  output logic [SEL_W-1:0]    sel_low,
  output logic [SEL_W-1:0]    sel_alt
);
  localparam int OFF_W = $clog2(CFG_REG_COUNT);
  localparam logic [DATA_W:0] BASE_V = (DATA_W+1)'(REG_BASE);
  localparam logic [DATA_W:0] LAST_V = (DATA_W+1)'(REG_BASE + CFG_REG_COUNT);

  logic [DATA_W-1:0] index_q;
  logic [DATA_W-1:0] store [CFG_REG_COUNT];
  logic [CFG_REG_COUNT-1:0] we;
  logic              hit;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    hit = ({1'b0, index_q} >= BASE_V) && ({1'b0, index_q} < LAST_V);
    off = index_q[OFF_W-1:0] - BASE_V[OFF_W-1:0];
  end

  generate
    for (genvar r = 0; r < CFG_REG_COUNT; r++) begin : g_we
      assign we[r] = wr && (win_port_e'(sel) == WIN_DATA) && hit && (off == OFF_W'(r));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
    end else if (wr && (win_port_e'(sel) == WIN_INDEX)) begin
      index_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < CFG_REG_COUNT; r++) begin
      if (rst) begin
        store[r] <= '0;
      end else if (we[r]) begin
        store[r] <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = hit ? store[off] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= (win_port_e'(sel) == WIN_INDEX) ? index_q : rd_mux;
    end
  end

  assign en_bit  = store[REG_LOW_OFF][EN_BIT];
  assign base    = {store[REG_HIGH_OFF], store[REG_LOW_OFF]} & BASE_MASK;
  assign src_alt = store[REG_CHOOSE_OFF][CHOOSE_BIT];
  assign sel_low = store[REG_LOW_OFF][SEL_FIELD_LSB +: SEL_W];
  assign sel_alt = store[REG_ALT_OFF][SEL_FIELD_LSB +: SEL_W];
endmodule

// File: rtl/cfgwin_sel_hold.sv
module cfgwin_sel_hold #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             src_alt,
  input  logic [SEL_W-1:0] sel_low,
  input  logic [SEL_W-1:0] sel_alt,
  output logic [SEL_W-1:0] active,
  output logic             pending
);
  logic [SEL_W-1:0] wanted;

  always_comb begin
    wanted = src_alt ? sel_alt : sel_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
    end else if (!busy) begin
      active <= wanted;
    end
  end

  assign pending = (wanted != active);
endmodule

// File: rtl/cfgwin_od_mux.sv
module cfgwin_od_mux #(
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 2
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic                 host_scl_oe,
  input  logic                 host_sda_oe,
  output logic                 host_scl_in,
  output logic                 host_sda_in,
  output logic [NUM_PORTS-1:0] port_scl_oe,
  output logic [NUM_PORTS-1:0] port_sda_oe,
  input  logic [NUM_PORTS-1:0] port_scl_in,
  input  logic [NUM_PORTS-1:0] port_sda_in
);
  logic [NUM_PORTS-1:0] hot;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign hot[p]         = (sel == SEL_W'(p));
      assign port_scl_oe[p] = hot[p] & host_scl_oe;
      assign port_sda_oe[p] = hot[p] & host_sda_oe;
    end
  endgenerate

  assign host_scl_in = |(hot & port_scl_in);
  assign host_sda_in = |(hot & port_sda_in);
endmodule

// File: rtl/cfgwin_port_router.sv
module cfgwin_port_router #(
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 4,
  parameter int REG_BASE  = 8'h2C,
  parameter logic [2*DATA_W-1:0] BASE_MASK = 16'hFFE0,
  localparam int SEL_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 win_wr,
  input  logic                 win_rd,
  input  logic                 win_sel,
  input  logic [DATA_W-1:0]    win_wdata,
  output logic [DATA_W-1:0]    win_rdata,
  input  logic                 ctrl_busy,
  output logic                 ctrl_en,
  output logic [2*DATA_W-1:0]  ctrl_base,
  output logic [SEL_W-1:0]     port_sel,
  output logic                 sel_pending,
  input  logic                 host_scl_oe,
  input  logic                 host_sda_oe,
  output logic                 host_scl_in,
  output logic                 host_sda_in,
  output logic [NUM_PORTS-1:0] port_scl_oe,
  output logic [NUM_PORTS-1:0] port_sda_oe,
  input  logic [NUM_PORTS-1:0] port_scl_in,
  input  logic [NUM_PORTS-1:0] port_sda_in
);
  logic             src_alt;
  logic [SEL_W-1:0] sel_low;
  logic [SEL_W-1:0] sel_alt;

  cfgwin_space #(
    .DATA_W(DATA_W), .REG_BASE(REG_BASE), .SEL_W(SEL_W), .BASE_MASK(BASE_MASK)
  ) u_space (
    .clk(clk), .rst(rst), .wr(win_wr), .rd(win_rd), .sel(win_sel),
    .wdata(win_wdata), .rdata(win_rdata), .en_bit(ctrl_en), .base(ctrl_base),
    .src_alt(src_alt), .sel_low(sel_low), .sel_alt(sel_alt)
  );

  cfgwin_sel_hold #(.SEL_W(SEL_W)) u_hold (
    .clk(clk), .rst(rst), .busy(ctrl_busy), .src_alt(src_alt),
    .sel_low(sel_low), .sel_alt(sel_alt), .active(port_sel), .pending(sel_pending)
  );

  cfgwin_od_mux #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_mux (
    .sel(port_sel), .host_scl_oe(host_scl_oe), .host_sda_oe(host_sda_oe),
    .host_scl_in(host_scl_in), .host_sda_in(host_sda_in),
    .port_scl_oe(port_scl_oe), .port_sda_oe(port_sda_oe),
    .port_scl_in(port_scl_in), .port_sda_in(port_sda_in)
  );
endmodule

// File: rtl/cfgwin_port_router_chk.sv
module cfgwin_port_router_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 4,
  parameter int REG_BASE  = 8'h2C,
  parameter logic [2*DATA_W-1:0] BASE_MASK = 16'hFFE0,
  parameter int SEL_W     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 win_wr,
  input logic                 win_sel,
  input logic [DATA_W-1:0]    win_wdata,
  input logic                 ctrl_busy,
  input logic                 ctrl_en,
  input logic [2*DATA_W-1:0]  ctrl_base,
  input logic [SEL_W-1:0]     port_sel,
  input logic                 sel_pending,
  input logic [NUM_PORTS-1:0] port_scl_oe,
  input logic [NUM_PORTS-1:0] port_sda_oe
);
  logic [DATA_W-1:0] idx_shadow;

  always_ff @(posedge clk) begin
    if (rst) idx_shadow <= '0;
    else if (win_wr && !win_sel) idx_shadow <= win_wdata;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (port_sel == '0) && !ctrl_en && !sel_pending); // R1

  AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (win_wr && win_sel && (idx_shadow == DATA_W'(REG_BASE)))
      |=> (ctrl_en == $past(win_wdata[0]))); // R5

  AST_BASE_HIGH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (win_wr && win_sel && (idx_shadow == DATA_W'(REG_BASE + 1)))
      |=> (ctrl_base[2*DATA_W-1:DATA_W] == ($past(win_wdata) & BASE_MASK[2*DATA_W-1:DATA_W]))); // R6

  AST_IDLE_CLEARS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_busy && !win_wr) |=> !sel_pending); // R8

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    ctrl_busy |=> $stable(port_sel)); // R9

  AST_ONE_PORT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_scl_oe) && $onehot0(port_sda_oe)); // R10
endmodule

bind cfgwin_port_router cfgwin_port_router_chk #(
  .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS), .REG_BASE(REG_BASE),
  .BASE_MASK(BASE_MASK), .SEL_W(SEL_W)
) i_chk (
  .clk(clk), .rst(rst), .win_wr(win_wr), .win_sel(win_sel), .win_wdata(win_wdata),
  .ctrl_busy(ctrl_busy), .ctrl_en(ctrl_en), .ctrl_base(ctrl_base),
  .port_sel(port_sel), .sel_pending(sel_pending),
  .port_scl_oe(port_scl_oe), .port_sda_oe(port_sda_oe)
);

// File: tb/test_cfgwin_port_router.sv
`timescale 1ns/1ps
module test_cfgwin_port_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic win_wr = 1'b0, win_rd = 1'b0, win_sel = 1'b0;
  logic [7:0] win_wdata = '0;
  logic [7:0] win_rdata;
  logic ctrl_busy = 1'b0;
  logic ctrl_en;
  logic [15:0] ctrl_base;
  logic [1:0] port_sel;
  logic sel_pending;
  logic host_scl_oe = 1'b0, host_sda_oe = 1'b0;
  logic host_scl_in, host_sda_in;
  logic [3:0] port_scl_oe, port_sda_oe;
  logic [3:0] port_scl_in = 4'hF, port_sda_in = 4'hF;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfgwin_port_router i_cfgwin_port_router (
    .clk(clk), .rst(rst), .win_wr(win_wr), .win_rd(win_rd), .win_sel(win_sel),
    .win_wdata(win_wdata), .win_rdata(win_rdata), .ctrl_busy(ctrl_busy),
    .ctrl_en(ctrl_en), .ctrl_base(ctrl_base), .port_sel(port_sel),
    .sel_pending(sel_pending), .host_scl_oe(host_scl_oe), .host_sda_oe(host_sda_oe),
    .host_scl_in(host_scl_in), .host_sda_in(host_sda_in),
    .port_scl_oe(port_scl_oe), .port_sda_oe(port_sda_oe),
    .port_scl_in(port_scl_in), .port_sda_in(port_sda_in)
  );

  // {index, data, exp_sel, exp_en, exp_base, exp_readback}; state accumulates
  localparam logic [42:0] VEC [9] = '{
    {8'h2C, 8'h01, 2'd0, 1'b1, 16'h0000, 8'h01},
    {8'h2C, 8'hE5, 2'd2, 1'b1, 16'h00E0, 8'hE5},
    {8'h2D, 8'hA7, 2'd2, 1'b1, 16'hA7E0, 8'hA7},
    {8'h2E, 8'h06, 2'd2, 1'b1, 16'hA7E0, 8'h06},
    {8'h2F, 8'h01, 2'd3, 1'b1, 16'hA7E0, 8'h01},
    {8'h2E, 8'h02, 2'd1, 1'b1, 16'hA7E0, 8'h02},
    {8'h2C, 8'h3C, 2'd1, 1'b0, 16'hA720, 8'h3C},
    {8'h2F, 8'hFE, 2'd2, 1'b0, 16'hA720, 8'hFE},
    {8'h50, 8'hFF, 2'd2, 1'b0, 16'hA720, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    win_wr = 1'b1; win_sel = a; win_wdata = d;
    @(negedge clk);
    win_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    win_rd = 1'b1; win_sel = a;
    @(negedge clk);
    win_rd = 1'b0;
    d = win_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 port_sel", port_sel, 0);
    chk("R1 ctrl_en", ctrl_en, 0);
    chk("R1 ctrl_base", ctrl_base, 0);
    chk("R1 sel_pending", sel_pending, 0);
    rd(1'b0, d); chk("R1 index", d, 0);
    rd(1'b1, d); chk("R1 R3 unmapped read", d, 0);

    for (int i = 0; i < 9; i++) begin
      wr(1'b0, VEC[i][42:35]);
      wr(1'b1, VEC[i][34:27]);
      @(negedge clk);
      chk("R7 R8 port_sel", port_sel, VEC[i][26:25]);
      chk("R5 ctrl_en", ctrl_en, VEC[i][24]);
      chk("R6 ctrl_base", ctrl_base, VEC[i][23:8]);
      rd(1'b1, d); chk("R4 R3 readback", d, VEC[i][7:0]);
    end

    // R9: selection held while busy
    @(negedge clk); ctrl_busy = 1'b1;
    wr(1'b0, 8'h2F);
    wr(1'b1, 8'h01);
    @(negedge clk);
    chk("R9 held sel", port_sel, 2);
    chk("R9 pending", sel_pending, 1);
    repeat (3) @(negedge clk);
    chk("R9 still held", port_sel, 2);
    ctrl_busy = 1'b0;
    @(negedge clk);
    chk("R9 applied", port_sel, 1);
    chk("R9 pending clear", sel_pending, 0);

    // R8: one edge after the write
    wr(1'b0, 8'h2E);
    wr(1'b1, 8'h06);
    chk("R8 not yet", port_sel, 1);
    chk("R8 pending", sel_pending, 1);
    @(negedge clk);
    chk("R8 applied", port_sel, 3);
    chk("R8 pending clear", sel_pending, 0);

    // R2 / R3
    rd(1'b0, d); chk("R2 index readback", d, 8'h2E);
    wr(1'b0, 8'h2D);
    rd(1'b1, d); chk("R3 neighbour kept", d, 8'hA7);
    wr(1'b0, 8'h2C);
    rd(1'b1, d); chk("R3 low kept", d, 8'h3C);

    // R10: routing on port 3
    @(negedge clk);
    host_scl_oe = 1'b1; host_sda_oe = 1'b1;
    port_scl_in = 4'b0111; port_sda_in = 4'b1000;
    #1;
    chk("R10 scl_oe", port_scl_oe, 4'b1000);
    chk("R10 sda_oe", port_sda_oe, 4'b1000);
    chk("R10 scl_in", host_scl_in, 0);
    chk("R10 sda_in", host_sda_in, 1);
    host_sda_oe = 1'b0; port_scl_in = 4'b0000; port_sda_in = 4'b1111;
    #1;
    chk("R10 sda released", port_sda_oe, 4'b0000);
    chk("R10 unselected ignored", host_scl_in, 0);
    chk("R10 sda_in high", host_sda_in, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule